// File: doc/BRIEF.md
# Comparator Output Conditioning

This block is the digital back end of a pair of analog comparators. Each comparator's raw decision arrives as a one-bit input. The block turns it into a final logic level and a set of edge events. The analog comparison, hysteresis, input routing and reference generation are outside this block. The raw decision is simply sampled as a digital level.

For each comparator the block applies three steps in order:
- an enable gate;
- an optional inversion;
- a blanking mask that forces the result low while a chosen timer compare window is active. The window source is picked per comparator from three timer compare signals by a one-hot selector.

The conditioned level is reported as a status bit. A per-comparator window-output switch can replace the final output with the XOR of the two paired comparators. The final output drives a pin path and a timer path together. Rising and falling edges of the final output become single-cycle events for an interrupt controller, each with its own sensitivity enables.

Top module: `cmp_out_cond`

## Requirements
- R1: While and right after reset, `riseEvt` and `fallEvt` are all 0.
- R2: A comparator with its enable at 0 reports status 0 whatever its raw input, inversion or blanking is. It raises no rise or fall event in the cycle after the clock edge at which it was disabled.
- R3: With the comparator enabled and no blanking, status equals the raw input when the invert bit is 0, and its complement when the invert bit is 1.
- R4: Each comparator's blanking selector is 5 bits wide. Bit 0 picks timer source 0, bit 1 picks source 1 and bit 2 picks source 2. The source bits of comparator i sit at `blankSrc[3i+2:3i]`. While any picked source is high and bits 4:3 are zero, status is forced to 0. A source that is high but not picked has no effect.
- R5: A selector with bit 3 or bit 4 set is reserved and acts as no blanking, whatever the timer sources are.
- R6: Inversion is applied before blanking, so an inverted low input under an active blanking window still reports 0.
- R7: With the window-output bit of comparator i at 0, its final output equals its own status. With the bit at 1, the final output equals the XOR of the statuses of comparators 2k and 2k+1 (its pair).
- R8: `pinOut` and `timOut` both equal the final output of each comparator in the same cycle.
- R9: Each comparator has a 2-bit sense field at `edgeSense[2i+1:2i]`; bit 0 of the field enables rising events. When an enabled comparator's final output is 1 at a clock edge after being 0 at the previous edge, and rising sense is set, `riseEvt` is high for exactly the one cycle after that edge.
- R10: Bit 1 of the sense field enables falling events in the same way: a 1-to-0 change of the final output gives a one-cycle `fallEvt` pulse. With both sense bits set, both directions are reported, never both in the same cycle.
- R11: An edge in a direction whose sense bit is 0 raises no event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| rawCmp | input | NCMP | Raw comparator decisions |
| cmpEn | input | NCMP | Per-comparator enable |
| cmpInv | input | NCMP | Per-comparator output inversion |
| blankSel | input | NCMP*SEL_W | Blanking selectors, SEL_W bits per comparator |
| blankSrc | input | NCMP*NSRC | Timer compare windows, NSRC per comparator |
| winSel | input | NCMP | Window-output (pair XOR) select |
| edgeSense | input | 2*NCMP | Bit 0 rising, bit 1 falling sensitivity per comparator |
| cmpStatus | output | NCMP | Level after inversion and blanking |
| pinOut | output | NCMP | Final output toward the pin |
| timOut | output | NCMP | Final output toward timer inputs |
| riseEvt | output | NCMP | One-cycle rising-edge events |
| fallEvt | output | NCMP | One-cycle falling-edge events |

## Verification
The bench builds the block with its defaults: two comparators, a 5-bit selector and three timer sources.

Two comparators form exactly one XOR pair, so window output can be tried on one side and on both sides, with each partner enabled or disabled. The 5-bit selector leaves two upper bits above the three source bits, so reserved codes can be mixed with valid source bits. Three sources per comparator allow a source to be high while a different one is picked.

// File: rtl/cmpcond_pkg.sv
package cmpcond_pkg;
  // Edge strobes handed from the control to the datapath, one per comparator
  typedef struct packed {
    logic rise;
    logic fall;
  } edgeStrobe_t;
endpackage

// File: rtl/cmpcond_ctrl.sv
module cmpcond_ctrl
  import cmpcond_pkg::*;
#(
  parameter int NCMP = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCMP-1:0]       finalOut,
  input  logic [NCMP-1:0]       cmpEn,
  input  logic [2*NCMP-1:0]     edgeSense,
  output edgeStrobe_t [NCMP-1:0] strobes,
  input  logic [NCMP-1:0]       riseEvt,
  input  logic [NCMP-1:0]       fallEvt
);
  logic [NCMP-1:0] prevOut;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevOut <= '0;
    else       prevOut <= finalOut;
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_edge
    always_comb begin
      strobes[i].rise = cmpEn[i] & edgeSense[2*i]   &  finalOut[i] & ~prevOut[i];
      strobes[i].fall = cmpEn[i] & edgeSense[2*i+1] & ~finalOut[i] &  prevOut[i];
    end

    // R9: a rising event cannot repeat on the next cycle
    a_r9_rise_once: assert property (@(posedge clk) disable iff (!rstN)
      riseEvt[i] |=> !riseEvt[i]);
    // R10: a falling event cannot repeat on the next cycle
    a_r10_fall_once: assert property (@(posedge clk) disable iff (!rstN)
      fallEvt[i] |=> !fallEvt[i]);
    // R10: never both directions at once
    a_r10_excl: assert property (@(posedge clk) disable iff (!rstN)
      !(riseEvt[i] && fallEvt[i]));
  end
endmodule

// File: rtl/cmpcond_dp.sv
module cmpcond_dp
  import cmpcond_pkg::*;
#(
  parameter int NCMP  = 2,
  parameter int SEL_W = 5,
  parameter int NSRC  = 3
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NCMP-1:0]        rawCmp,
  input  logic [NCMP-1:0]        cmpEn,
  input  logic [NCMP-1:0]        cmpInv,
  input  logic [NCMP*SEL_W-1:0]  blankSel,
  input  logic [NCMP*NSRC-1:0]   blankSrc,
  input  logic [NCMP-1:0]        winSel,
  input  edgeStrobe_t [NCMP-1:0] strobes,
  output logic [NCMP-1:0]        status,
  output logic [NCMP-1:0]        finalOut,
  output logic [NCMP-1:0]        riseEvt,
  output logic [NCMP-1:0]        fallEvt
);
  localparam int RSV_W = SEL_W - NSRC;

  logic [NCMP-1:0] blankOn;
  logic [NCMP-1:0] selValid;

  for (genvar i = 0; i < NCMP; i++) begin : g_cond
    logic [SEL_W-1:0] sel;
    logic [NSRC-1:0]  src;
    logic             polOut;
    assign sel = blankSel[i*SEL_W +: SEL_W];
    assign src = blankSrc[i*NSRC +: NSRC];

    if (RSV_W > 0) begin : g_rsv
      assign selValid[i] = (sel[SEL_W-1:NSRC] == '0);
    end else begin : g_norsv
      assign selValid[i] = 1'b1;
    end

    assign blankOn[i] = selValid[i] & (|(sel[NSRC-1:0] & src));
    assign polOut     = cmpEn[i] & (rawCmp[i] ^ cmpInv[i]);
    assign status[i]  = polOut & ~blankOn[i];

    localparam int PARTNER = (i % 2 == 0) ? i + 1 : i - 1;
    assign finalOut[i] = winSel[i] ? (status[i] ^ status[PARTNER]) : status[i];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        riseEvt[i] <= 1'b0;
        fallEvt[i] <= 1'b0;
      end else begin
        riseEvt[i] <= strobes[i].rise;
        fallEvt[i] <= strobes[i].fall;
      end
    end

    // R2: disabled comparator reports zero status
    a_r2_dis_zero: assert property (@(posedge clk) disable iff (!rstN)
      !cmpEn[i] |-> !status[i]);
    // R2: no event after an edge at which the comparator was disabled
    a_r2_dis_no_evt: assert property (@(posedge clk) disable iff (!rstN)
      !cmpEn[i] |=> !(riseEvt[i] || fallEvt[i]));
    // R4: picked source 0 active under a valid code blanks the output
    a_r4_blank_src0: assert property (@(posedge clk) disable iff (!rstN)
      (sel[0] && src[0] && sel[SEL_W-1:NSRC] == '0) |-> !status[i]);
    // R5: reserved code leaves the polarity result untouched
    a_r5_rsv_pass: assert property (@(posedge clk) disable iff (!rstN)
      (cmpEn[i] && sel[SEL_W-1:NSRC] != '0) |-> (status[i] == (rawCmp[i] ^ cmpInv[i])));
  end
endmodule

// File: rtl/cmp_out_cond.sv
module cmp_out_cond
  import cmpcond_pkg::*;
#(
  parameter int NCMP  = 2,
  parameter int SEL_W = 5,
  parameter int NSRC  = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NCMP-1:0]       rawCmp,
  input  logic [NCMP-1:0]       cmpEn,
  input  logic [NCMP-1:0]       cmpInv,
  input  logic [NCMP*SEL_W-1:0] blankSel,
  input  logic [NCMP*NSRC-1:0]  blankSrc,
  input  logic [NCMP-1:0]       winSel,
  input  logic [2*NCMP-1:0]     edgeSense,
  output logic [NCMP-1:0]       cmpStatus,
  output logic [NCMP-1:0]       pinOut,
  output logic [NCMP-1:0]       timOut,
  output logic [NCMP-1:0]       riseEvt,
  output logic [NCMP-1:0]       fallEvt
);
  edgeStrobe_t [NCMP-1:0] strobes;
  logic [NCMP-1:0]        finalOut;

  cmpcond_dp #(.NCMP(NCMP), .SEL_W(SEL_W), .NSRC(NSRC)) u_dp (
    .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .cmpEn(cmpEn), .cmpInv(cmpInv),
    .blankSel(blankSel), .blankSrc(blankSrc), .winSel(winSel),
    .strobes(strobes), .status(cmpStatus), .finalOut(finalOut),
    .riseEvt(riseEvt), .fallEvt(fallEvt)
  );

  cmpcond_ctrl #(.NCMP(NCMP)) u_ctrl (
    .clk(clk), .rstN(rstN), .finalOut(finalOut), .cmpEn(cmpEn),
    .edgeSense(edgeSense), .strobes(strobes),
    .riseEvt(riseEvt), .fallEvt(fallEvt)
  );

  assign pinOut = finalOut;
  assign timOut = finalOut;

  // R1: no events during reset
  always_comb begin
    if (!rstN) a_r1_reset_quiet: assert ((riseEvt == '0) && (fallEvt == '0));
  end
endmodule

// File: tb/sim_cmp_out_cond.sv
module sim_cmp_out_cond;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] rawCmp = '0, cmpEn = '0, cmpInv = '0, winSel = '0;
  logic [9:0] blankSel = '0;
  logic [5:0] blankSrc = '0;
  logic [3:0] edgeSense = '0;
  logic [1:0] cmpStatus, pinOut, timOut, riseEvt, fallEvt;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  logic [1:0] mPrev = '0;

  typedef struct {
    string      tag;
    logic [1:0] st;
    logic [1:0] out;
    logic [1:0] rise;
    logic [1:0] fall;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmp_out_cond u0 (
    .clk(clk), .rstN(rstN), .rawCmp(rawCmp), .cmpEn(cmpEn), .cmpInv(cmpInv),
    .blankSel(blankSel), .blankSrc(blankSrc), .winSel(winSel),
    .edgeSense(edgeSense), .cmpStatus(cmpStatus), .pinOut(pinOut),
    .timOut(timOut), .riseEvt(riseEvt), .fallEvt(fallEvt)
  );

  task automatic chk(string tag, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and push the expected results
  task automatic step(string tag, logic [1:0] raw, logic [1:0] en, logic [1:0] inv,
                      logic [9:0] bsel, logic [5:0] bsrc, logic [1:0] win, logic [3:0] sense);
    item_t it;
    logic [1:0] st, out;
    @(negedge clk);
    rawCmp = raw; cmpEn = en; cmpInv = inv; blankSel = bsel;
    blankSrc = bsrc; winSel = win; edgeSense = sense;
    for (int i = 0; i < 2; i++) begin
      logic [4:0] s;
      logic pol, blk;
      s   = bsel[i*5 +: 5];
      pol = en[i] ? (raw[i] ^ inv[i]) : 1'b0;
      blk = (s[4:3] == 2'b00) && ((s[2:0] & bsrc[i*3 +: 3]) != 3'b000);
      st[i] = pol & ~blk;
    end
    for (int i = 0; i < 2; i++) out[i] = win[i] ? (st[0] ^ st[1]) : st[i];
    it.tag = tag; it.st = st; it.out = out;
    for (int i = 0; i < 2; i++) begin
      it.rise[i] = en[i] & sense[2*i]   &  out[i] & ~mPrev[i];
      it.fall[i] = en[i] & sense[2*i+1] & ~out[i] &  mPrev[i];
    end
    mPrev = out;
    q.push_back(it);
  endtask

  // Monitor: compare after each edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        chk(it.tag, "status", cmpStatus, it.st);
        chk(it.tag, "pinOut", pinOut, it.out);
        chk({it.tag, "/R8"}, "timOut", timOut, it.out);
        chk(it.tag, "riseEvt", riseEvt, it.rise);
        chk(it.tag, "fallEvt", fallEvt, it.fall);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "riseEvt in reset", riseEvt, 2'b00);
    chk("R1", "fallEvt in reset", fallEvt, 2'b00);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", "riseEvt after reset", riseEvt, 2'b00);
    chk("R1", "fallEvt after reset", fallEvt, 2'b00);

    // R3 polarity, no blanking, sense off
    step("R3", 2'b01, 2'b11, 2'b00, '0, '0, 2'b00, 4'b0000);
    step("R3", 2'b10, 2'b11, 2'b00, '0, '0, 2'b00, 4'b0000);
    step("R3", 2'b01, 2'b11, 2'b11, '0, '0, 2'b00, 4'b0000);
    step("R3", 2'b00, 2'b11, 2'b00, '0, '0, 2'b00, 4'b0000);
    // R9 rising events with rise sense only
    step("R9", 2'b11, 2'b11, 2'b00, '0, '0, 2'b00, 4'b0101);
    step("R9", 2'b11, 2'b11, 2'b00, '0, '0, 2'b00, 4'b0101);
    // R11 falling edge ignored with rise-only sense
    step("R11", 2'b00, 2'b11, 2'b00, '0, '0, 2'b00, 4'b0101);
    // R10 falling events, then both directions
    step("R10", 2'b11, 2'b11, 2'b00, '0, '0, 2'b00, 4'b1010);
    step("R10", 2'b00, 2'b11, 2'b00, '0, '0, 2'b00, 4'b1010);
    step("R10", 2'b01, 2'b11, 2'b00, '0, '0, 2'b00, 4'b1111);
    step("R10", 2'b10, 2'b11, 2'b00, '0, '0, 2'b00, 4'b1111);
    // R2 disable: status 0, and the falling edge it causes raises no event
    step("R2", 2'b11, 2'b00, 2'b11, '0, '0, 2'b00, 4'b1111);
    step("R2", 2'b00, 2'b00, 2'b00, '0, '0, 2'b00, 4'b1111);
    step("R2", 2'b11, 2'b00, 2'b00, '0, '0, 2'b00, 4'b1111);
    // R4 blanking per selector bit
    step("R4", 2'b11, 2'b11, 2'b00, {5'b00010, 5'b00001}, {3'b010, 3'b001}, 2'b00, 4'b0000);
    step("R4", 2'b11, 2'b11, 2'b00, {5'b00100, 5'b00100}, {3'b100, 3'b000}, 2'b00, 4'b0000);
    step("R4", 2'b11, 2'b11, 2'b00, {5'b00001, 5'b00010}, {3'b110, 3'b101}, 2'b00, 4'b0000);
    step("R4", 2'b11, 2'b11, 2'b00, {5'b00111, 5'b00011}, {3'b100, 3'b010}, 2'b00, 4'b0000);
    // R5 reserved codes behave as no blanking
    step("R5", 2'b11, 2'b11, 2'b00, {5'b10001, 5'b01111}, 6'b111111, 2'b00, 4'b0000);
    step("R5", 2'b01, 2'b11, 2'b10, {5'b11000, 5'b01001}, 6'b111111, 2'b00, 4'b0000);
    // R6 inversion before blanking
    step("R6", 2'b00, 2'b11, 2'b11, {5'b00001, 5'b00001}, {3'b001, 3'b001}, 2'b00, 4'b0000);
    step("R6", 2'b00, 2'b11, 2'b11, {5'b00001, 5'b00001}, {3'b000, 3'b001}, 2'b00, 4'b0000);
    // R7 window output XOR
    step("R7", 2'b01, 2'b11, 2'b00, '0, '0, 2'b10, 4'b0000);
    step("R7", 2'b11, 2'b11, 2'b00, '0, '0, 2'b11, 4'b0000);
    step("R7", 2'b10, 2'b11, 2'b00, '0, '0, 2'b11, 4'b0000);
    step("R7", 2'b01, 2'b01, 2'b00, '0, '0, 2'b11, 4'b0000);
    // R9 rise via window output change
    step("R9", 2'b00, 2'b11, 2'b00, '0, '0, 2'b11, 4'b1111);
    step("R9", 2'b01, 2'b11, 2'b00, '0, '0, 2'b11, 4'b1111);
    step("R10", 2'b11, 2'b11, 2'b00, '0, '0, 2'b11, 4'b1111);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule